// File: doc/BRIEF.md
# Trace Packet Emitter with Timestamps

This block gathers three kinds of trace traffic into one byte-wide stream for a downstream formatter. Software posts short values to a small bank of stimulus ports over a write-only register bus. A watchpoint unit hands over pre-formed event records, and the same unit raises a trigger line that asks for a synchronization marker. A free-running timestamp counter measures the time between packets. After any other packet has gone out, the block sends the elapsed count as a timestamp packet and restarts the count.

The stream leaves on a valid/ready byte interface. Bytes of one packet are never mixed with bytes of another. When several sources wait at once, a fixed priority picks the next one. One global enable gates all of it. While that enable is low, nothing new is started and software writes and triggers are lost.

Top module: `trace_pkt_emitter`

## Requirements
- R1: Each rising edge of `wpTrig` seen while `traceEn` is high causes one synchronization packet of six bytes, sent in the order 00 00 00 00 00 80. Edges that occur while a sync packet is still waiting are merged into that one packet.
- R2: A software write with `busSize` of 1, 2 or 3 to port `busAddr` below NPORTS produces a header byte {port[4:0], size[1:0], 1} in bits 7:3, 2:1 and 0. The header is followed by 1, 2 or 4 payload bytes from `busWrData`, least significant byte first. A write with size code 0, or with an address at or above NPORTS, has no effect.
- R3: A hardware record accepted when `hwValid` and `hwReady` are both high is sent unchanged as HW_BYTES bytes, least significant byte first.
- R4: When several packets wait, they are sent in this order: sync first, then hardware record, then software stimulus, then timestamp. Among the stimulus ports the lowest port number goes first. Once a packet has started, it is sent completely before the next one begins.
- R5: When a packet that is not a timestamp finishes while the counter is nonzero, a timestamp packet is queued. That packet carries the counter in 7-bit groups, lowest group first, using only as many groups as the value needs. Bit 7 is set on every byte except the last. Starting the timestamp packet clears the counter.
- R6: With `tsSrcSel`=0 the counter advances on every clock cycle. With `tsSrcSel`=1 it advances on cycles with `bitTick` high. In both cases it is divided first by 1, 4, 16 or 64 for `tsPrescale` codes 0, 1, 2 and 3.
- R7: Once the counter reaches its all-ones value it stays there until a timestamp packet clears it.
- R8: `portReady[p]` is low while port p holds a value that has not yet started to be sent. A valid write to a port that is not ready is dropped and sets `stimOverflow`. That flag stays set until reset.
- R9: While `traceEn` is low, no new packet starts. Writes and triggers are ignored, `hwReady` is low and the counter does not advance.
- R10: After reset, `outValid` is low, every `portReady` bit is high, `stimOverflow` is low and `hwReady` equals `traceEn`.
- R11: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| traceEn | input | 1 | Global trace enable |
| busWrEn | input | 1 | Stimulus write strobe |
| busAddr | input | 5 | Stimulus port number |
| busSize | input | 2 | Payload size code (1, 2 or 4 bytes) |
| busWrData | input | 32 | Stimulus payload |
| portReady | output | NPORTS | Per-port ready flags |
| stimOverflow | output | 1 | Sticky dropped-write flag |
| hwValid | input | 1 | Hardware record offered |
| hwRecord | input | 8*HW_BYTES | Hardware record contents |
| hwReady | output | 1 | Hardware record can be taken |
| wpTrig | input | 1 | Watchpoint trigger, edge sensitive |
| tsSrcSel | input | 1 | Counter source: 0 core clock, 1 bit tick |
| bitTick | input | 1 | Trace bit-clock tick enable |
| tsPrescale | input | 2 | Prescaler code |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Output byte |
| outReady | input | 1 | Downstream accepts byte |

## Verification
A wrong pending flag shows up at the ports. It is either a packet missing from the byte stream or a duplicated one within one packet time, or a `portReady` bit that stays low when it should rise. A fault in arbitration or packet framing gives a wrong byte order, which is visible in the first bytes after several sources are made to wait behind a stalled output. A counter or prescaler fault only becomes visible in the timestamp bytes that follow the next packet, so the bench drives known tick counts through the bit-tick input and then reads back the exact encoded value.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int PKT_BYTES = 6;

  typedef enum logic [1:0] {
    SRC_SYNC = 2'd0,
    SRC_HW   = 2'd1,
    SRC_STIM = 2'd2,
    SRC_TS   = 2'd3
  } srcT;

  typedef struct packed {
    logic load;   // capture a new packet from src
    srcT  src;    // source being loaded or currently sent
    logic shift;  // one byte accepted downstream
    logic done;   // last byte of the packet accepted
  } ctrlStrobeT;

  typedef struct packed {
    logic sync;
    logic hw;
    logic stim;
    logic ts;
  } reqT;
endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       traceEn,
  input  reqT        req,
  input  logic       lastByte,
  input  logic       outReady,
  output ctrlStrobeT stb,
  output logic       outValid
);
  logic busyQ;
  srcT  srcQ;
  srcT  grant;

  always_comb begin
    if (req.sync)      grant = SRC_SYNC;
    else if (req.hw)   grant = SRC_HW;
    else if (req.stim) grant = SRC_STIM;
    else               grant = SRC_TS;
    stb.load  = !busyQ && traceEn && (req.sync || req.hw || req.stim || req.ts);
    stb.src   = busyQ ? srcQ : grant;
    stb.shift = busyQ && outReady;
    stb.done  = busyQ && outReady && lastByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      srcQ  <= SRC_SYNC;
    end else if (stb.load) begin
      busyQ <= 1'b1;
      srcQ  <= grant;
    end else if (stb.done) begin
      busyQ <= 1'b0;
    end
  end

  assign outValid = busyQ;
endmodule

// File: rtl/trace_dpath.sv
module trace_dpath
  import trace_pkg::*;
#(
  parameter int NPORTS   = 4,
  parameter int HW_BYTES = 2,
  parameter int TS_W     = 21
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  traceEn,
  input  logic                  busWrEn,
  input  logic [4:0]            busAddr,
  input  logic [1:0]            busSize,
  input  logic [31:0]           busWrData,
  output logic [NPORTS-1:0]     portReady,
  output logic                  stimOverflow,
  input  logic                  hwValid,
  input  logic [8*HW_BYTES-1:0] hwRecord,
  output logic                  hwReady,
  input  logic                  wpTrig,
  input  logic                  tsSrcSel,
  input  logic                  bitTick,
  input  logic [1:0]            tsPrescale,
  input  ctrlStrobeT            stb,
  output reqT                   req,
  output logic                  lastByte,
  output logic [7:0]            outData
);
  localparam int IDX_W     = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int TS_GROUPS = (TS_W + 6) / 7;
  localparam int PAD_W     = 7 * TS_GROUPS;
  localparam int BUF_W     = 8 * PKT_BYTES;
  localparam logic [TS_W-1:0] TS_MAX = '1;

  // ---------------- stimulus port bank ----------------
  logic [NPORTS-1:0] stimPend;
  logic [31:0]       stimDataW [NPORTS];
  logic [1:0]        stimSizeW [NPORTS];
  logic              wrHit;
  logic              wrBlocked;
  logic [IDX_W-1:0]  stimSel;
  logic              takeStim;

  always_comb begin
    wrHit     = busWrEn && traceEn && (busSize != 2'd0) && ({1'b0, busAddr} < 6'(NPORTS));
    wrBlocked = 1'b0;
    for (int i = 0; i < NPORTS; i++)
      if (busAddr == 5'(i) && stimPend[i]) wrBlocked = 1'b1;
    stimSel = '0;
    for (int i = NPORTS - 1; i >= 0; i--)
      if (stimPend[i]) stimSel = IDX_W'(i);
  end

  assign takeStim = stb.load && (stb.src == SRC_STIM);

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic        pend;
    logic [31:0] data;
    logic [1:0]  size;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pend <= 1'b0;
        data <= '0;
        size <= '0;
      end else if (takeStim && stimSel == IDX_W'(p)) begin
        pend <= 1'b0;
      end else if (wrHit && busAddr == 5'(p) && !pend) begin
        pend <= 1'b1;
        data <= busWrData;
        size <= busSize;
      end
    end
    assign stimPend[p]  = pend;
    assign stimDataW[p] = data;
    assign stimSizeW[p] = size;
    assign portReady[p] = !pend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      stimOverflow <= 1'b0;
    else if (wrHit && wrBlocked)    stimOverflow <= 1'b1;
  end

  // ---------------- hardware record slot ----------------
  logic                  hwFull;
  logic [8*HW_BYTES-1:0] hwBuf;

  assign hwReady = traceEn && !hwFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hwFull <= 1'b0;
      hwBuf  <= '0;
    end else if (stb.load && stb.src == SRC_HW) begin
      hwFull <= 1'b0;
    end else if (hwValid && hwReady) begin
      hwFull <= 1'b1;
      hwBuf  <= hwRecord;
    end
  end

  // ---------------- sync request from trigger edge ----------------
  logic trigQ;
  logic syncPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigQ    <= 1'b0;
      syncPend <= 1'b0;
    end else begin
      trigQ <= wpTrig;
      if (wpTrig && !trigQ && traceEn)            syncPend <= 1'b1;
      else if (stb.load && stb.src == SRC_SYNC)   syncPend <= 1'b0;
    end
  end

  // ---------------- prescaler and timestamp counter ----------------
  logic            baseTick;
  logic            tsTick;
  logic [5:0]      divCnt;
  logic [5:0]      divLimit;
  logic [TS_W-1:0] tsCnt;
  logic            tsPend;

  always_comb begin
    case (tsPrescale)
      2'd0:    divLimit = 6'd0;
      2'd1:    divLimit = 6'd3;
      2'd2:    divLimit = 6'd15;
      default: divLimit = 6'd63;
    endcase
    baseTick = traceEn && (tsSrcSel ? bitTick : 1'b1);
    tsTick   = baseTick && (divCnt >= divLimit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      tsCnt  <= '0;
      tsPend <= 1'b0;
    end else begin
      if (baseTick) divCnt <= tsTick ? 6'd0 : divCnt + 6'd1;
      if (stb.load && stb.src == SRC_TS)     tsCnt <= '0;
      else if (tsTick && tsCnt != TS_MAX)    tsCnt <= tsCnt + 1'b1;
      if (stb.load && stb.src == SRC_TS)                       tsPend <= 1'b0;
      else if (stb.done && stb.src != SRC_TS && tsCnt != '0)   tsPend <= 1'b1;
    end
  end

  assign req = '{sync: syncPend, hw: hwFull, stim: |stimPend, ts: tsPend};

  // ---------------- packet builder and byte shifter ----------------
  logic [BUF_W-1:0] nxtBuf;
  logic [2:0]       nxtLen;
  logic [PAD_W-1:0] tsPad;
  int               tsLen;
  logic [BUF_W-1:0] pktBuf;
  logic [2:0]       remQ;

  always_comb begin
    tsPad = PAD_W'(tsCnt);
    tsLen = 1;
    for (int g = 1; g < TS_GROUPS; g++)
      if ((tsPad >> (7 * g)) != '0) tsLen = g + 1;
    nxtBuf = '0;
    nxtLen = 3'd1;
    case (stb.src)
      SRC_SYNC: begin
        nxtBuf[BUF_W-1 -: 8] = 8'h80;
        nxtLen = 3'd6;
      end
      SRC_HW: begin
        nxtBuf[8*HW_BYTES-1:0] = hwBuf;
        nxtLen = 3'(HW_BYTES);
      end
      SRC_STIM: begin
        nxtBuf[7:0]  = {5'(stimSel), stimSizeW[stimSel], 1'b1};
        nxtBuf[39:8] = stimDataW[stimSel];
        case (stimSizeW[stimSel])
          2'd1:    nxtLen = 3'd2;
          2'd2:    nxtLen = 3'd3;
          default: nxtLen = 3'd5;
        endcase
      end
      default: begin
        for (int g = 0; g < TS_GROUPS; g++)
          nxtBuf[8*g +: 8] = {(g < tsLen - 1), tsPad[7*g +: 7]};
        nxtLen = 3'(tsLen);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktBuf <= '0;
      remQ   <= '0;
    end else if (stb.load) begin
      pktBuf <= nxtBuf;
      remQ   <= nxtLen;
    end else if (stb.shift) begin
      pktBuf <= pktBuf >> 8;
      remQ   <= remQ - 3'd1;
    end
  end

  assign lastByte = (remQ == 3'd1);
  assign outData  = pktBuf[7:0];
endmodule

// File: rtl/trace_pkt_emitter.sv
module trace_pkt_emitter
  import trace_pkg::*;
#(
  parameter int NPORTS   = 4,
  parameter int HW_BYTES = 2,
  parameter int TS_W     = 21
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  traceEn,
  input  logic                  busWrEn,
  input  logic [4:0]            busAddr,
  input  logic [1:0]            busSize,
  input  logic [31:0]           busWrData,
  output logic [NPORTS-1:0]     portReady,
  output logic                  stimOverflow,
  input  logic                  hwValid,
  input  logic [8*HW_BYTES-1:0] hwRecord,
  output logic                  hwReady,
  input  logic                  wpTrig,
  input  logic                  tsSrcSel,
  input  logic                  bitTick,
  input  logic [1:0]            tsPrescale,
  output logic                  outValid,
  output logic [7:0]            outData,
  input  logic                  outReady
);
  ctrlStrobeT stb;
  reqT        req;
  logic       lastByte;

  trace_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .traceEn(traceEn), .req(req),
    .lastByte(lastByte), .outReady(outReady), .stb(stb), .outValid(outValid)
  );

  trace_dpath #(.NPORTS(NPORTS), .HW_BYTES(HW_BYTES), .TS_W(TS_W)) u_dpath (
    .clk(clk), .rstN(rstN), .traceEn(traceEn),
    .busWrEn(busWrEn), .busAddr(busAddr), .busSize(busSize), .busWrData(busWrData),
    .portReady(portReady), .stimOverflow(stimOverflow),
    .hwValid(hwValid), .hwRecord(hwRecord), .hwReady(hwReady),
    .wpTrig(wpTrig), .tsSrcSel(tsSrcSel), .bitTick(bitTick), .tsPrescale(tsPrescale),
    .stb(stb), .req(req), .lastByte(lastByte), .outData(outData)
  );
endmodule

// File: rtl/trace_chk.sv
module trace_chk #(
  parameter int NPORTS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              traceEn,
  input logic              busWrEn,
  input logic [4:0]        busAddr,
  input logic [1:0]        busSize,
  input logic [NPORTS-1:0] portReady,
  input logic              stimOverflow,
  input logic              outValid,
  input logic [7:0]        outData,
  input logic              outReady
);
  logic wrValid;
  logic portFree;

  always_comb begin
    wrValid  = busWrEn && traceEn && (busSize != 2'd0) && ({1'b0, busAddr} < 6'(NPORTS));
    portFree = 1'b0;
    for (int i = 0; i < NPORTS; i++)
      if (busAddr == 5'(i)) portFree = portReady[i];
  end

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData)); // R11

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    stimOverflow |=> stimOverflow); // R8

  AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !portFree |=> stimOverflow); // R8

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !traceEn && !outValid |=> !outValid); // R9

  for (genvar p = 0; p < NPORTS; p++) begin : g_take
    AST_PORT_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
      wrValid && busAddr == 5'(p) && portReady[p] |=> !portReady[p]); // R8
  end
endmodule

bind trace_pkt_emitter trace_chk #(.NPORTS(NPORTS)) u_chk (
  .clk(clk), .rstN(rstN), .traceEn(traceEn), .busWrEn(busWrEn),
  .busAddr(busAddr), .busSize(busSize), .portReady(portReady),
  .stimOverflow(stimOverflow), .outValid(outValid), .outData(outData),
  .outReady(outReady)
);

// File: tb/sim_trace_pkt_emitter.sv
`timescale 1ns/1ps
module sim_trace_pkt_emitter;
  localparam int NP  = 4;
  localparam int HWB = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          traceEn = 1'b0, busWrEn = 1'b0, hwValid = 1'b0, wpTrig = 1'b0;
  logic          tsSrcSel = 1'b1, bitTick = 1'b0, outReady = 1'b1;
  logic [4:0]    busAddr = '0;
  logic [1:0]    busSize = '0, tsPrescale = '0;
  logic [31:0]   busWrData = '0;
  logic [15:0]   hwRecord = '0;
  logic [NP-1:0] portReady;
  logic          stimOverflow, hwReady, outValid;
  logic [7:0]    outData;

  logic          u1Trig = 1'b0, u1Valid, u1Ovf, u1HwReady;
  logic [7:0]    u1Data;
  logic [NP-1:0] u1Ready;

  trace_pkt_emitter #(.NPORTS(NP), .HW_BYTES(HWB)) u0 (
    .clk(clk), .rstN(rstN), .traceEn(traceEn), .busWrEn(busWrEn), .busAddr(busAddr),
    .busSize(busSize), .busWrData(busWrData), .portReady(portReady),
    .stimOverflow(stimOverflow), .hwValid(hwValid), .hwRecord(hwRecord),
    .hwReady(hwReady), .wpTrig(wpTrig), .tsSrcSel(tsSrcSel), .bitTick(bitTick),
    .tsPrescale(tsPrescale), .outValid(outValid), .outData(outData), .outReady(outReady)
  );

  // small counter instance for the saturation case
  trace_pkt_emitter #(.NPORTS(NP), .HW_BYTES(HWB), .TS_W(9)) u1 (
    .clk(clk), .rstN(rstN), .traceEn(1'b1), .busWrEn(1'b0), .busAddr(5'd0),
    .busSize(2'd0), .busWrData(32'd0), .portReady(u1Ready),
    .stimOverflow(u1Ovf), .hwValid(1'b0), .hwRecord(16'd0),
    .hwReady(u1HwReady), .wpTrig(u1Trig), .tsSrcSel(1'b0), .bitTick(1'b0),
    .tsPrescale(2'd0), .outValid(u1Valid), .outData(u1Data), .outReady(1'b1)
  );

  int passN = 0, totN = 0;
  bit finished = 1'b0;
  logic [7:0] cap  [0:127];
  logic [7:0] cap1 [0:15];
  int capN = 0, capBase = 0, cap1N = 0;

  always @(negedge clk) begin
    if (outValid && outReady && capN < 128) begin cap[capN] = outData; capN++; end
    if (u1Valid && cap1N < 16) begin cap1[cap1N] = u1Data; cap1N++; end
  end

  typedef struct packed {
    logic [4:0]  port;
    logic [1:0]  size;
    logic [31:0] data;
    logic [2:0]  len;
    logic [47:0] exp;
  } vecT;

  localparam vecT VEC [5] = '{
    '{5'd0, 2'd1, 32'h0000_00A5, 3'd2, 48'h0000_0000_A503},
    '{5'd2, 2'd2, 32'h0000_1234, 3'd3, 48'h0000_0012_3415},
    '{5'd3, 2'd3, 32'hDEAD_BEEF, 3'd5, 48'h00DE_ADBE_EF1F},
    '{5'd1, 2'd1, 32'hFFFF_FF00, 3'd2, 48'h0000_0000_000B},
    '{5'd3, 2'd2, 32'h0000_CAFE, 3'd3, 48'h0000_00CA_FE1D}
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    totN++;
    if (act === exp) passN++;
    else $display("FAIL %s: actual %0h expected %0h", req, act, exp);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic waitN(input int n);
    repeat (n) tick();
  endtask

  task automatic mark();
    capBase = capN;
  endtask

  // compare bytes captured since mark(): count in the top word, bytes below
  task automatic chkPkt(input string req, input int n, input logic [95:0] exp);
    logic [95:0] got = '0;
    int k = capN - capBase;
    for (int i = 0; i < k && i < 12; i++) got[8*i +: 8] = cap[capBase + i];
    chk(req, {32'(k), got}, {32'(n), exp});
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [1:0] s, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busSize = s; busWrData = d;
    tick();
    busWrEn = 1'b0;
  endtask

  task automatic trigPulse();
    wpTrig = 1'b1; tick(); wpTrig = 1'b0; tick();
  endtask

  task automatic bitPulses(input int n);
    bitTick = 1'b1; waitN(n); bitTick = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", passN, totN);
    end
  endtask

  initial begin
    #750000;
    if (!finished) begin
      totN++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
      $finish;
    end
  end

  initial begin
    waitN(3);
    rstN = 1'b1;
    waitN(2);
    // R10: reset state
    chk("R10 outValid", 128'(outValid), 128'(0));
    chk("R10 portReady", 128'(portReady), 128'(4'hF));
    chk("R10 overflow", 128'(stimOverflow), 128'(0));
    chk("R10 hwReady off", 128'(hwReady), 128'(0));

    // R9: disabled, writes, triggers and ticks are ignored
    mark();
    busWrite(5'd0, 2'd1, 32'h11);
    busWrite(5'd0, 2'd1, 32'h22);
    trigPulse();
    bitPulses(5);
    waitN(10);
    chkPkt("R9 no packet while off", 0, '0);
    chk("R9 ready while off", 128'(portReady), 128'(4'hF));
    chk("R9 no overflow while off", 128'(stimOverflow), 128'(0));

    traceEn = 1'b1;
    tick();
    chk("R10 hwReady on", 128'(hwReady), 128'(1));

    // R2: stimulus vectors; counter is still zero so no timestamp follows
    for (int v = 0; v < 5; v++) begin
      mark();
      busWrite(VEC[v].port, VEC[v].size, VEC[v].data);
      waitN(15);
      chkPkt($sformatf("R2 vector %0d", v), int'(VEC[v].len), 96'(VEC[v].exp));
    end

    // R2: size code 0 and out-of-range port have no effect
    mark();
    busWrite(5'd0, 2'd0, 32'hAA);
    busWrite(5'd7, 2'd1, 32'hBB);
    waitN(10);
    chkPkt("R2 ignored writes", 0, '0);
    chk("R2 ready after ignored writes", 128'(portReady), 128'(4'hF));

    // R1: sync packet
    mark();
    trigPulse();
    waitN(12);
    chkPkt("R1 sync bytes", 6, 96'h80_00_00_00_00_00);

    // R3: hardware record
    mark();
    hwValid = 1'b1; hwRecord = 16'hBEEF; tick(); hwValid = 1'b0;
    waitN(10);
    chkPkt("R3 hw record", 2, 96'hBE_EF);

    // R4: priority with a stalled output, R8 overflow on busy port
    mark();
    outReady = 1'b0;
    busWrite(5'd1, 2'd1, 32'h11);
    waitN(2);
    busWrite(5'd0, 2'd1, 32'h22);
    hwValid = 1'b1; hwRecord = 16'h3344; tick(); hwValid = 1'b0;
    trigPulse();
    busWrite(5'd0, 2'd1, 32'h99);
    tick();
    chk("R8 port busy flag", 128'(portReady), 128'(4'b1110));
    chk("R8 overflow set", 128'(stimOverflow), 128'(1));
    outReady = 1'b1;
    waitN(40);
    chkPkt("R4 priority order", 12, 96'h22_03_33_44_80_00_00_00_00_00_11_0B);

    // R5: timestamp after a packet, then cleared
    mark();
    bitPulses(5);
    busWrite(5'd2, 2'd1, 32'h55);
    waitN(15);
    chkPkt("R5 single group timestamp", 3, 96'h05_55_13);
    mark();
    busWrite(5'd2, 2'd1, 32'h56);
    waitN(15);
    chkPkt("R5 counter cleared", 2, 96'h56_13);

    // R5: two-group timestamp with continuation bit
    mark();
    bitPulses(200);
    busWrite(5'd0, 2'd1, 32'h00);
    waitN(15);
    chkPkt("R5 two group timestamp", 4, 96'h01_C8_00_03);

    // R6: prescaler divide by 4 and by 64
    mark();
    tsPrescale = 2'd1;
    bitPulses(8);
    busWrite(5'd1, 2'd1, 32'h7E);
    waitN(15);
    chkPkt("R6 divide by 4", 3, 96'h02_7E_0B);
    mark();
    tsPrescale = 2'd3;
    bitPulses(128);
    busWrite(5'd1, 2'd1, 32'h7F);
    waitN(15);
    chkPkt("R6 divide by 64", 3, 96'h02_7F_0B);

    // R6: core clock source
    mark();
    tsPrescale = 2'd0;
    tsSrcSel = 1'b0;
    waitN(3);
    tsSrcSel = 1'b1;
    busWrite(5'd2, 2'd1, 32'h01);
    waitN(15);
    chkPkt("R6 core clock source", 3, 96'h03_01_13);

    // R9: counter frozen while disabled
    mark();
    traceEn = 1'b0;
    tsSrcSel = 1'b0;
    waitN(10);
    trigPulse();
    tsSrcSel = 1'b1;
    traceEn = 1'b1;
    waitN(3);
    chkPkt("R9 trigger ignored while off", 0, '0);
    busWrite(5'd3, 2'd1, 32'h02);
    waitN(15);
    chkPkt("R9 counter frozen while off", 2, 96'h02_1B);
    chk("R8 overflow sticky", 128'(stimOverflow), 128'(1));

    // R7: saturated 9-bit counter in the second instance
    u1Trig = 1'b1; tick(); u1Trig = 1'b0;
    waitN(30);
    begin
      logic [95:0] got = '0;
      for (int i = 0; i < cap1N && i < 12; i++) got[8*i +: 8] = cap1[i];
      chk("R7 saturated timestamp", {32'(cap1N), got}, {32'd8, 96'h03_FF_80_00_00_00_00_00});
    end

    report();
    $finish;
  end
endmodule